// File: doc/BRIEF.md
# Pipelined Multi-Operand Carry-Save Adder Tree

This block adds a parameterised number of unsigned operands of equal width and returns their exact total. The operands are first widened with zeros to the result width. A tree of carry-save rows then reduces them. Each row is a bank of independent full adders that turns three words into a sum word and a carry word; the carry word moves up one bit position before the next level. One ordinary carry-propagate addition at the bottom of the tree turns the last two words into the result.

The depth of the tree follows the series 2, 3, 4, 6, 9, 13, 19, 28, ..., where each entry is the floor of 3/2 times the one before it. The number of levels L is the index of the first entry that is not below the operand count. The first level trims the operand count down to the entry just below it. Every later level steps down one entry, until two words remain. For example, twelve operands need five levels, not the ten rows of a linear chain.

A parameter chooses the register density: a register after every level, or after every second level. The final sum is always registered. A valid flag travels with the data. The block accepts a new operand set on every clock.

Top module: `cst_tree`

## Requirements
- R1: When `sum_vld` is high, `sum_out` equals the exact arithmetic sum of the operand set accepted LAT cycles earlier. `sum_out` is WIDTH + ceil(log2 N_OPS) bits wide. Operand i occupies bits [i*WIDTH +: WIDTH] of `ops_in`.
- R2: An operand set is accepted at a rising edge where `in_vld` is high. `sum_vld` is then high for exactly one cycle, after the LAT-th following rising edge. LAT = floor(L / REG_EVERY) + 1, and L is the smallest j for which entry j of the series 2, 3, 4, 6, 9, 13, ... (entry 0 = 2) is at least N_OPS. With N_OPS = 12 and REG_EVERY = 1, LAT = 6.
- R3: Operand sets presented on consecutive cycles each produce a result on consecutive cycles, in the order they were presented.
- R4: While `rst_n` is low, `sum_vld` is 0 and `sum_out` is 0.
- R5: In a cycle where `sum_vld` is low, `sum_out` keeps its previous value, whatever `ops_in` holds while `in_vld` is low.
- R6: If every operand is 2^WIDTH - 1, the result is N_OPS * (2^WIDTH - 1), with no truncation.
- R7: A set with a single nonzero operand gives that operand's value, whichever slot it occupies.
- R8: With REG_EVERY = 2 the results are the same as with REG_EVERY = 1. For N_OPS = 12 they arrive after LAT = 3 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand set on `ops_in` is valid this cycle |
| ops_in | input | N_OPS*WIDTH | Packed unsigned operands, operand i at bits [i*WIDTH +: WIDTH] |
| sum_vld | output | 1 | `sum_out` carries a new result this cycle |
| sum_out | output | WIDTH+$clog2(N_OPS) | Total of one operand set |

## Verification
The assertions take for granted that `in_vld` is a clean 0 or 1 at each rising edge, and that reset is applied before the first operand set. Under those conditions the flag pipeline and the result register must track each other exactly. The bound check assumes the operands are unsigned, so no accepted set can exceed N_OPS*(2^WIDTH-1). The stimulus changes inputs only on falling edges and holds reset for several cycles before the first set. It drives arbitrary operand values while `in_vld` is low, so the hold property is tested against live input activity.

// File: rtl/cst_pkg.sv
package cst_pkg;

   // number of reduction levels: first series entry (2,3,4,6,9,...) not below k
   function automatic int seq_len(input int k);
      int d;
      int l;
      d = 2;
      l = 0;
      while (d < k) begin
         d = (d * 3) / 2;
         l = l + 1;
      end
      return l;
   endfunction

   // series entry j, entry 0 being 2
   function automatic int seq_val(input int j);
      int d;
      d = 2;
      for (int i = 0; i < j; i++) d = (d * 3) / 2;
      return d;
   endfunction

   // operand words entering level lv (lv = levels means the final pair)
   function automatic int ops_at(input int k, input int lv);
      if (lv == 0) return k;
      return seq_val(seq_len(k) - lv);
   endfunction

   // register stages from operand input to result output
   function automatic int stage_regs(input int k, input int every);
      return seq_len(k) / every + 1;
   endfunction

endpackage

// File: rtl/csa_row.sv
module csa_row #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] s,
   output logic [W-1:0] cy
);
   logic [W-1:0] maj;

   for (genvar i = 0; i < W; i++) begin : g_fa
      assign s[i]   = a[i] ^ b[i] ^ c[i];
      assign maj[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
   end

   // carry weight moves up one bit; the top carry is beyond the result range
   assign cy = {maj[W-2:0], 1'b0};

   logic unused_top;
   assign unused_top = maj[W-1];
endmodule

// File: rtl/cst_level.sv
module cst_level #(
   parameter int NTOT    = 12,
   parameter int W       = 8,
   parameter int IN_CNT  = 12,
   parameter int OUT_CNT = 9,
   parameter int REG     = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [NTOT*W-1:0] in_bus,
   output logic            out_vld,
   output logic [NTOT*W-1:0] out_bus
);
   localparam int NCSA  = IN_CNT - OUT_CNT;
   localparam int NPASS = IN_CNT - 3 * NCSA;

   logic [NTOT*W-1:0] nxt;

   for (genvar j = 0; j < NCSA; j++) begin : g_row
      csa_row #(.W(W)) u_row (
         .a  (in_bus[(3*j)*W +: W]),
         .b  (in_bus[(3*j+1)*W +: W]),
         .c  (in_bus[(3*j+2)*W +: W]),
         .s  (nxt[(2*j)*W +: W]),
         .cy (nxt[(2*j+1)*W +: W])
      );
   end

   if (NPASS > 0) begin : g_pass
      assign nxt[2*NCSA*W +: NPASS*W] = in_bus[3*NCSA*W +: NPASS*W];
   end

   assign nxt[NTOT*W-1:OUT_CNT*W] = '0;

   if (IN_CNT < NTOT) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^in_bus[NTOT*W-1:IN_CNT*W];
   end

   if (REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld <= 1'b0;
            out_bus <= '0;
         end else begin
            out_vld <= in_vld;
            if (in_vld) out_bus <= nxt;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_vld    = in_vld;
      assign out_bus    = nxt;
   end
endmodule

// File: rtl/cst_final.sv
module cst_final #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         out_vld,
   output logic [W-1:0] out_sum
);
   logic [W-1:0] total;
   assign total = a + b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_sum <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_sum <= total;
      end
   end
endmodule

// File: rtl/cst_tree.sv
module cst_tree
   import cst_pkg::*;
#(
   parameter int N_OPS     = 12,
   parameter int WIDTH     = 16,
   parameter int REG_EVERY = 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_vld,
   input  logic [N_OPS*WIDTH-1:0]            ops_in,
   output logic                              sum_vld,
   output logic [WIDTH+$clog2(N_OPS)-1:0]    sum_out
);
   localparam int RW     = WIDTH + $clog2(N_OPS);
   localparam int LEVELS = seq_len(N_OPS);

   initial begin
      assert (N_OPS >= 3) else $error("cst_tree: N_OPS must be at least 3");
      assert (WIDTH >= 1) else $error("cst_tree: WIDTH must be at least 1");
      assert (REG_EVERY == 1 || REG_EVERY == 2)
         else $error("cst_tree: REG_EVERY must be 1 or 2");
   end

   logic [LEVELS:0][N_OPS*RW-1:0] bus;
   logic [LEVELS:0]               vld;

   for (genvar i = 0; i < N_OPS; i++) begin : g_ext
      assign bus[0][i*RW +: RW] = {{(RW-WIDTH){1'b0}}, ops_in[i*WIDTH +: WIDTH]};
   end
   assign vld[0] = in_vld;

   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
      cst_level #(
         .NTOT    (N_OPS),
         .W       (RW),
         .IN_CNT  (ops_at(N_OPS, lv)),
         .OUT_CNT (ops_at(N_OPS, lv + 1)),
         .REG     ((((lv + 1) % REG_EVERY) == 0) ? 1 : 0)
      ) u_lvl (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_vld  (vld[lv]),
         .in_bus  (bus[lv]),
         .out_vld (vld[lv+1]),
         .out_bus (bus[lv+1])
      );
   end

   logic unused_rest;
   assign unused_rest = ^bus[LEVELS][N_OPS*RW-1:2*RW];

   cst_final #(.W(RW)) u_fin (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (vld[LEVELS]),
      .a       (bus[LEVELS][0 +: RW]),
      .b       (bus[LEVELS][RW +: RW]),
      .out_vld (sum_vld),
      .out_sum (sum_out)
   );
endmodule

// File: rtl/cst_tree_chk.sv
module cst_tree_chk
   import cst_pkg::*;
#(
   parameter int N_OPS     = 12,
   parameter int WIDTH     = 16,
   parameter int REG_EVERY = 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           in_vld,
   input logic [N_OPS*WIDTH-1:0]         ops_in,
   input logic                           sum_vld,
   input logic [WIDTH+$clog2(N_OPS)-1:0] sum_out
);
   localparam int RW  = WIDTH + $clog2(N_OPS);
   localparam int LAT = stage_regs(N_OPS, REG_EVERY);
   localparam logic [RW:0] MAXSUM =
      (RW+1)'(N_OPS) * (((RW+1)'(1) << WIDTH) - (RW+1)'(1));

   logic [LAT-1:0] vpipe;
   logic [LAT-1:0] zpipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpipe <= '0;
         zpipe <= '0;
      end else begin
         vpipe <= {vpipe[LAT-2:0], in_vld};
         zpipe <= {zpipe[LAT-2:0], (ops_in == '0)};
      end
   end

   // R2: result flag appears exactly LAT edges after acceptance
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sum_vld == vpipe[LAT-1]);

   // R1, R6: no result exceeds the largest reachable total
   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sum_vld |-> ({1'b0, sum_out} <= MAXSUM));

   // R5: output frozen in idle cycles
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sum_vld |-> $stable(sum_out));

   // R7: an all-zero set yields zero
   p_zero_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_vld && zpipe[LAT-1]) |-> (sum_out == '0));
endmodule

bind cst_tree cst_tree_chk #(
   .N_OPS     (N_OPS),
   .WIDTH     (WIDTH),
   .REG_EVERY (REG_EVERY)
) u_chk (.*);

// File: tb/cst_tree_bench.sv
module cst_tree_bench;
   localparam int CLK_NS = 10;
   localparam int K      = 12;
   localparam int W      = 8;
   localparam int RW     = W + $clog2(K);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_vld = 1'b0;
   logic [K*W-1:0]    ops = '0;
   logic              vld_a, vld_b;
   logic [RW-1:0]     sum_a, sum_b;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int lat_a, lat_b;
   bit done = 1'b0;
   string req = "R4";

   int            due_a[$], due_b[$];
   logic [RW-1:0] exp_a[$], exp_b[$];
   logic [RW-1:0] last_a = '0, last_b = '0;

   always #(CLK_NS/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cst_tree #(.N_OPS(K), .WIDTH(W), .REG_EVERY(1)) u_cst_tree (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .ops_in(ops),
      .sum_vld(vld_a), .sum_out(sum_a));

   cst_tree #(.N_OPS(K), .WIDTH(W), .REG_EVERY(2)) u_cst_tree_pair (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .ops_in(ops),
      .sum_vld(vld_b), .sum_out(sum_b));

   function automatic int depth(input int k);
      int d = 2;
      int l = 0;
      while (d < k) begin
         d = d * 3 / 2;
         l++;
      end
      return l;
   endfunction

   task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, expv);
      end
   endtask

   task automatic cmp(input string who, input string lat_tag, input logic v,
                      input logic [RW-1:0] s, ref int dq[$],
                      ref logic [RW-1:0] eq[$], ref logic [RW-1:0] last);
      if (dq.size() > 0 && dq[0] == cyc) begin
         chk({who, " ", lat_tag, " valid"}, RW'(v), RW'(1));
         chk({who, " ", req, " sum"}, s, eq[0]);
         last = eq[0];
         void'(dq.pop_front());
         void'(eq.pop_front());
      end else begin
         chk({who, " ", lat_tag, " idle"}, RW'(v), RW'(0));
         chk({who, " R5 hold"}, s, last);
      end
   endtask

   task automatic step(input logic v, input logic [K*W-1:0] o);
      logic [RW-1:0] t;
      @(negedge clk);
      cmp("a", "R2", vld_a, sum_a, due_a, exp_a, last_a);
      cmp("b", "R8", vld_b, sum_b, due_b, exp_b, last_b);
      in_vld = v;
      ops    = o;
      if (v) begin
         t = '0;
         for (int i = 0; i < K; i++) t = t + RW'(o[i*W +: W]);
         due_a.push_back(cyc + lat_a);
         exp_a.push_back(t);
         due_b.push_back(cyc + lat_b);
         exp_b.push_back(t);
      end
   endtask

   function automatic logic [K*W-1:0] rnd_ops();
      logic [K*W-1:0] r;
      for (int i = 0; i < K; i++) r[i*W +: W] = W'($urandom);
      return r;
   endfunction

   initial begin
      lat_a = depth(K) + 1;
      lat_b = depth(K) / 2 + 1;
      // R4: reset state
      repeat (3) begin
         @(negedge clk);
         chk("a R4 reset valid", RW'(vld_a), '0);
         chk("a R4 reset sum", sum_a, '0);
         chk("b R4 reset valid", RW'(vld_b), '0);
         chk("b R4 reset sum", sum_b, '0);
      end
      rst_n = 1'b1;

      // R6: all operands at maximum
      req = "R6";
      step(1'b1, '1);
      for (int i = 0; i < 8; i++) step(1'b0, rnd_ops());

      // R7: single nonzero operand in each slot, plus an all-zero set
      req = "R7";
      for (int s = 0; s < K; s++) begin
         logic [K*W-1:0] o;
         o = '0;
         o[s*W +: W] = W'(8'hA0 + s);
         step(1'b1, o);
      end
      step(1'b1, '0);
      for (int i = 0; i < 8; i++) step(1'b0, rnd_ops());

      // R1: random sets with random gaps
      req = "R1";
      for (int i = 0; i < 60; i++) step(1'(($urandom % 3) != 0), rnd_ops());
      for (int i = 0; i < 8; i++) step(1'b0, rnd_ops());

      // R3: back-to-back burst
      req = "R3";
      for (int i = 0; i < 40; i++) step(1'b1, rnd_ops());
      for (int i = 0; i < 10; i++) step(1'b0, rnd_ops());

      chk("a R2 drained", RW'(due_a.size()), '0);
      chk("b R8 drained", RW'(due_b.size()), '0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule